// File: doc/BRIEF.md
# Segment Translation Fault Classifier

This block sits beside the address-translation path of a 32-bit core and decides, for one access at a time, whether translation succeeds and what kind of fault to raise when it does not. It receives the control bits of the selected segment register, the privilege state, whether translation is enabled, the access kind (instruction fetch, data load, data store) and the access class (integer, floating point, reservation, cache management, external control). The page-table walk is not part of this block: its hit/miss flag and the read/write/execute permissions of the matching entry arrive as inputs.

One cycle after a request it presents a registered verdict. The verdict holds a pass flag, the exception kind, a 32-bit fault status word, the granted permissions, and a flag marking an untranslated pass-through. It also raises a one-cycle strobe whenever the fault belongs to the data side, so that the effective address can be captured into a fault-address register. Direct-store segments are handled completely here. Ordinary segments are judged on no-execute, page-table miss and permission, in that order.

Top module: `seg_fault_classifier`

## Requirements
- R1: With `real_mode` high the access passes whatever the other inputs are: exception 0 (none), status 0, permissions 3'b111 (bit0 read, bit1 write, bit2 execute), pass-through 1 and no capture.
- R2: A fetch (`acc_kind`=0) from a direct-store segment (`seg_flags[3]`=1) faults with instruction-storage exception (`res_exc`=1) and status 0x10000000, without a capture strobe.
- R3: A floating-point access (`acc_class`=1) to a direct-store segment raises an alignment exception (`res_exc`=3) with status 0, and strobes capture.
- R4: A reservation access (`acc_class`=2) to a direct-store segment raises data-storage (`res_exc`=2) with status 0x04000000 for a load (`acc_kind`=1) and 0x06000000 for a store (`acc_kind`=2), and strobes capture.
- R5: An external-control access (`acc_class`=4, and the unused codes 5 to 7) to a direct-store segment raises data-storage with status 0x04100000 for a load and 0x06100000 for a store, and strobes capture.
- R6: A cache-management access (`acc_class`=3) to a direct-store segment passes as an untranslated no-op: pass 1, pass-through 1, permissions 0, no capture, for either direction and either key.
- R7: The key is `seg_flags[1]` when `problem_state` is 1 and `seg_flags[2]` otherwise. An integer access (`acc_class`=0) to a direct-store segment is granted read+write (3'b011) when the key is 1 and read only (3'b001) when it is 0. It passes with pass-through 1 unless it is a store with key 0, which raises data-storage 0x0A000000 with capture.
- R8: In a segment that is not direct-store, a fetch with the no-execute bit (`seg_flags[0]`) set raises instruction-storage with status 0x10000000, whatever the table-walk result.
- R9: A page-table miss (`pt_hit`=0) raises instruction-storage 0x40000000 for a fetch, data-storage 0x40000000 for a load and data-storage 0x42000000 for a store.
- R10: On a hit, the access needs execute (fetch), write (store) or read (load or kind code 3) in `pt_prot`. A missing bit raises status 0x08000000 (instruction-storage for a fetch, data-storage for a load) or data-storage 0x0A000000 for a store. Otherwise the access passes with `res_prot` equal to `pt_prot` and pass-through 0.
- R11: `res_valid` is high exactly in the cycle after a cycle with `req_valid` high. `res_capture` pulses in that same cycle only for data-storage and alignment faults.
- R12: Precedence is real mode, then direct-store, then no-execute, then miss, then permission. No-execute affects only fetches. Every fault reports permissions 0 and a non-zero exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| real_mode | input | 1 | Translation disabled |
| problem_state | input | 1 | 1 = user privilege, 0 = supervisor |
| seg_flags | input | 4 | Segment control bits: [3] direct-store, [2] supervisor key, [1] user key, [0] no-execute |
| acc_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 treated as load |
| acc_class | input | 3 | 0 integer, 1 float, 2 reservation, 3 cache op, 4..7 external control |
| pt_hit | input | 1 | Page-table walk found an entry |
| pt_prot | input | 3 | Permissions of that entry: [0] read, [1] write, [2] execute |
| res_valid | output | 1 | Verdict valid |
| res_pass | output | 1 | Translation allowed |
| res_exc | output | 2 | 0 none, 1 instruction-storage, 2 data-storage, 3 alignment |
| res_status | output | 32 | Fault status word |
| res_prot | output | 3 | Granted permissions |
| res_passthru | output | 1 | Address used untranslated |
| res_capture | output | 1 | One-cycle strobe to capture the faulting address |

## Verification
Requests go back to back through every access class in a direct-store segment, in both directions and with both privilege states. Swapping which key bit is set separates the user key from the supervisor key, and a store with the unselected key set tells the two apart. Ordinary-segment requests combine the no-execute bit, hit or miss, and permission sets that lack exactly the needed bit. A second group stacks several fault causes on one request, and that group exposes any error in precedence. Idle gaps between bursts show that no verdict or capture strobe appears without a request.

// File: rtl/segfc_pkg.sv
package segfc_pkg;

  localparam int STAT_W = 32;
  localparam int PROT_W = 3;

  // permission bit positions
  localparam int PR_RD = 0;
  localparam int PR_WR = 1;
  localparam int PR_EX = 2;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_LOAD  = 2'd1,
    KIND_STORE = 2'd2,
    KIND_SPARE = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    CLS_INT   = 3'd0,
    CLS_FLOAT = 3'd1,
    CLS_RESV  = 3'd2,
    CLS_CACHE = 3'd3,
    CLS_EXTC  = 3'd4
  } acc_class_e;

  typedef enum logic [1:0] {
    EXC_NONE   = 2'd0,
    EXC_ISTORE = 2'd1,
    EXC_DSTORE = 2'd2,
    EXC_ALIGN  = 2'd3
  } exc_e;

  localparam logic [STAT_W-1:0] ST_NOEXEC   = 32'h1000_0000;
  localparam logic [STAT_W-1:0] ST_RESV_LD  = 32'h0400_0000;
  localparam logic [STAT_W-1:0] ST_RESV_ST  = 32'h0600_0000;
  localparam logic [STAT_W-1:0] ST_EXTC_LD  = 32'h0410_0000;
  localparam logic [STAT_W-1:0] ST_EXTC_ST  = 32'h0610_0000;
  localparam logic [STAT_W-1:0] ST_PROT_LD  = 32'h0800_0000;
  localparam logic [STAT_W-1:0] ST_PROT_ST  = 32'h0A00_0000;
  localparam logic [STAT_W-1:0] ST_MISS_LD  = 32'h4000_0000;
  localparam logic [STAT_W-1:0] ST_MISS_ST  = 32'h4200_0000;

  typedef struct packed {
    logic              pass;
    exc_e              exc;
    logic [STAT_W-1:0] status;
    logic [PROT_W-1:0] prot;
    logic              passthru;
  } verdict_t;

  function automatic logic [PROT_W-1:0] need_mask(acc_kind_e k);
    logic [PROT_W-1:0] m;
    m = '0;
    case (k)
      KIND_FETCH: m[PR_EX] = 1'b1;
      KIND_STORE: m[PR_WR] = 1'b1;
      default:    m[PR_RD] = 1'b1;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/segfc_seg_decode.sv
module segfc_seg_decode #(
  parameter int FLAG_W = 4,
  parameter int T_POS  = 3,
  parameter int KS_POS = 2,
  parameter int KP_POS = 1,
  parameter int NX_POS = 0
) (
  input  logic [FLAG_W-1:0] seg_flags,
  input  logic              problem_state,
  output logic              is_direct,
  output logic              no_exec,
  output logic              key
);
  always_comb begin
    is_direct = seg_flags[T_POS];
    no_exec   = seg_flags[NX_POS];
    // user privilege picks the user key, supervisor picks its own
    key       = problem_state ? seg_flags[KP_POS] : seg_flags[KS_POS];
  end
endmodule

// File: rtl/segfc_ds_classifier.sv
module segfc_ds_classifier
  import segfc_pkg::*;
(
  input  acc_kind_e  kind,
  input  acc_class_e cls,
  input  logic       key,
  output verdict_t   verdict
);
  logic is_store;

  always_comb begin
    is_store = (kind == KIND_STORE);
    verdict  = '0;
    if (kind == KIND_FETCH) begin
      // code may never run from a direct-store area
      verdict.exc    = EXC_ISTORE;
      verdict.status = ST_NOEXEC;
    end else begin
      case (cls)
        CLS_INT: begin
          if (is_store && !key) begin
            verdict.exc    = EXC_DSTORE;
            verdict.status = ST_PROT_ST;
          end else begin
            verdict.pass      = 1'b1;
            verdict.passthru  = 1'b1;
            verdict.prot      = '0;
            verdict.prot[PR_RD] = 1'b1;
            verdict.prot[PR_WR] = key;
          end
        end
        CLS_FLOAT: begin
          verdict.exc    = EXC_ALIGN;
          verdict.status = '0;
        end
        CLS_RESV: begin
          verdict.exc    = EXC_DSTORE;
          verdict.status = is_store ? ST_RESV_ST : ST_RESV_LD;
        end
        CLS_CACHE: begin
          // silent no-op: address untouched, nothing granted
          verdict.pass     = 1'b1;
          verdict.passthru = 1'b1;
        end
        default: begin
          verdict.exc    = EXC_DSTORE;
          verdict.status = is_store ? ST_EXTC_ST : ST_EXTC_LD;
        end
      endcase
    end
  end
endmodule

// File: rtl/segfc_page_classifier.sv
module segfc_page_classifier
  import segfc_pkg::*;
(
  input  acc_kind_e         kind,
  input  logic              no_exec,
  input  logic              pt_hit,
  input  logic [PROT_W-1:0] pt_prot,
  output verdict_t          verdict
);
  logic [PROT_W-1:0] need;
  logic              is_fetch;
  logic              is_store;
  logic              short_of;

  always_comb begin
    need     = need_mask(kind);
    is_fetch = (kind == KIND_FETCH);
    is_store = (kind == KIND_STORE);
    short_of = |(need & ~pt_prot);
    verdict  = '0;
    if (is_fetch && no_exec) begin
      verdict.exc    = EXC_ISTORE;
      verdict.status = ST_NOEXEC;
    end else if (!pt_hit) begin
      verdict.exc    = is_fetch ? EXC_ISTORE : EXC_DSTORE;
      verdict.status = is_store ? ST_MISS_ST : ST_MISS_LD;
    end else if (short_of) begin
      verdict.exc    = is_fetch ? EXC_ISTORE : EXC_DSTORE;
      verdict.status = is_store ? ST_PROT_ST : ST_PROT_LD;
    end else begin
      verdict.pass = 1'b1;
      verdict.prot = pt_prot;
    end
  end
endmodule

// File: rtl/seg_fault_classifier.sv
module seg_fault_classifier
  import segfc_pkg::*;
#(
  parameter int FLAG_W = 4,
  parameter int T_POS  = 3,
  parameter int KS_POS = 2,
  parameter int KP_POS = 1,
  parameter int NX_POS = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              real_mode,
  input  logic              problem_state,
  input  logic [FLAG_W-1:0] seg_flags,
  input  logic [1:0]        acc_kind,
  input  logic [2:0]        acc_class,
  input  logic              pt_hit,
  input  logic [2:0]        pt_prot,
  output logic              res_valid,
  output logic              res_pass,
  output logic [1:0]        res_exc,
  output logic [31:0]       res_status,
  output logic [2:0]        res_prot,
  output logic              res_passthru,
  output logic              res_capture
);
  localparam logic [PROT_W-1:0] PROT_ALL = {PROT_W{1'b1}};

  acc_kind_e  kind;
  acc_class_e cls;
  logic       is_direct, no_exec, key;
  verdict_t   ds_v, pg_v, nxt_v, cur_v;
  logic       nxt_cap;

  assign kind = acc_kind_e'(acc_kind);
  assign cls  = acc_class_e'(acc_class);

  segfc_seg_decode #(
    .FLAG_W(FLAG_W), .T_POS(T_POS), .KS_POS(KS_POS),
    .KP_POS(KP_POS), .NX_POS(NX_POS)
  ) u_seg (
    .seg_flags     (seg_flags),
    .problem_state (problem_state),
    .is_direct     (is_direct),
    .no_exec       (no_exec),
    .key           (key)
  );

  segfc_ds_classifier u_ds (
    .kind    (kind),
    .cls     (cls),
    .key     (key),
    .verdict (ds_v)
  );

  segfc_page_classifier u_pg (
    .kind    (kind),
    .no_exec (no_exec),
    .pt_hit  (pt_hit),
    .pt_prot (pt_prot),
    .verdict (pg_v)
  );

  // next-state: precedence real mode > direct-store > page path
  always_comb begin
    if (real_mode) begin
      nxt_v          = '0;
      nxt_v.pass     = 1'b1;
      nxt_v.prot     = PROT_ALL;
      nxt_v.passthru = 1'b1;
    end else if (is_direct) begin
      nxt_v = ds_v;
    end else begin
      nxt_v = pg_v;
    end
    nxt_cap = req_valid && !nxt_v.pass &&
              (nxt_v.exc == EXC_DSTORE || nxt_v.exc == EXC_ALIGN);
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_capture <= 1'b0;
      cur_v       <= '0;
    end else begin
      res_valid   <= req_valid;
      res_capture <= nxt_cap;
      if (req_valid) begin
        cur_v <= nxt_v;
      end
    end
  end

  assign res_pass     = cur_v.pass;
  assign res_exc      = cur_v.exc;
  assign res_status   = cur_v.status;
  assign res_prot     = cur_v.prot;
  assign res_passthru = cur_v.passthru;

  // ---------------- assertions ----------------
  assert_result_follows_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == $past(req_valid));

  assert_capture_data_side_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_capture |-> (res_valid && !res_pass &&
                     (res_exc == EXC_DSTORE || res_exc == EXC_ALIGN)));

  assert_real_mode_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(real_mode)) |->
      (res_pass && res_prot == PROT_ALL && res_passthru && !res_capture));

  assert_ds_fetch_denied_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(!real_mode && seg_flags[T_POS] && acc_kind == 2'd0)) |->
      (!res_pass && res_exc == EXC_ISTORE));

  assert_pass_has_need_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_pass && !res_passthru) |->
      ((need_mask(acc_kind_e'($past(acc_kind))) & ~res_prot) == '0));

  assert_fault_shape_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_pass) |-> (res_prot == '0 && res_exc != EXC_NONE));

endmodule

// File: tb/seg_fault_classifier_tb.sv
module seg_fault_classifier_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  typedef struct {
    logic        pass;
    logic [1:0]  exc;
    logic [31:0] status;
    logic [2:0]  prot;
    logic        passthru;
    logic        cap;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, real_mode, problem_state, pt_hit;
  logic [3:0]  seg_flags;
  logic [1:0]  acc_kind;
  logic [2:0]  acc_class, pt_prot;
  logic        res_valid, res_pass, res_passthru, res_capture;
  logic [1:0]  res_exc;
  logic [31:0] res_status;
  logic [2:0]  res_prot;

  exp_t sb[$];
  int   n_checks = 0;
  int   n_errors = 0;
  int   cycles   = 0;
  bit   done     = 1'b0;

  seg_fault_classifier u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .real_mode(real_mode),
    .problem_state(problem_state), .seg_flags(seg_flags), .acc_kind(acc_kind),
    .acc_class(acc_class), .pt_hit(pt_hit), .pt_prot(pt_prot),
    .res_valid(res_valid), .res_pass(res_pass), .res_exc(res_exc),
    .res_status(res_status), .res_prot(res_prot), .res_passthru(res_passthru),
    .res_capture(res_capture)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // flags: {direct-store, supervisor key, user key, no-execute}
  function automatic logic [3:0] sf(bit t, bit ks, bit kp, bit nx);
    return {t, ks, kp, nx};
  endfunction

  task automatic check(bit ok, string tag, string what);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  // driver: applies one request for one cycle and queues its expectation
  task automatic send(bit rm, bit ps, logic [3:0] fl, logic [1:0] k,
                      logic [2:0] c, bit hit, logic [2:0] pp,
                      bit e_pass, logic [1:0] e_exc, logic [31:0] e_st,
                      logic [2:0] e_prot, bit e_thru, bit e_cap, string tag);
    exp_t e;
    e.pass = e_pass; e.exc = e_exc; e.status = e_st; e.prot = e_prot;
    e.passthru = e_thru; e.cap = e_cap; e.tag = tag;
    @(negedge clk);
    req_valid = 1'b1; real_mode = rm; problem_state = ps; seg_flags = fl;
    acc_kind = k; acc_class = c; pt_hit = hit; pt_prot = pp;
    sb.push_back(e);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 1; i < n; i++) @(negedge clk);
  endtask

  // monitor: pops expectations as verdicts appear
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (res_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R11", "verdict without request");
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(res_pass == e.pass && res_exc == e.exc && res_status == e.status &&
                res_prot == e.prot && res_passthru == e.passthru && res_capture == e.cap,
                e.tag,
                $sformatf("got pass=%0d exc=%0d st=%h prot=%b thru=%0d cap=%0d exp pass=%0d exc=%0d st=%h prot=%b thru=%0d cap=%0d",
                          res_pass, res_exc, res_status, res_prot, res_passthru, res_capture,
                          e.pass, e.exc, e.status, e.prot, e.passthru, e.cap));
        end
      end else if (res_capture) begin
        check(1'b0, "R11", "capture strobe with no verdict");
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog: run hung, got cycles=%0d expected <=%0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; real_mode = 1'b0; problem_state = 1'b0;
    seg_flags = '0; acc_kind = '0; acc_class = '0; pt_hit = 1'b0; pt_prot = '0;
    repeat (3) @(negedge clk);
    check(res_valid == 1'b0 && res_capture == 1'b0 && res_pass == 1'b0, "R11",
          $sformatf("reset state got valid=%0d cap=%0d pass=%0d expected 0 0 0",
                    res_valid, res_capture, res_pass));
    rst_n = 1'b1;
    idle(2);

    // R1 real mode
    send(1,0,sf(1,0,0,1),2'd0,3'd1,0,3'b000, 1,2'd0,32'h0,3'b111,1,0,"R1");
    send(1,1,sf(0,0,0,0),2'd2,3'd0,0,3'b000, 1,2'd0,32'h0,3'b111,1,0,"R1");
    // R2 direct-store fetch
    send(0,0,sf(1,1,1,0),2'd0,3'd0,1,3'b111, 0,2'd1,32'h1000_0000,3'b000,0,0,"R2");
    // R3 float
    send(0,0,sf(1,1,1,0),2'd1,3'd1,1,3'b111, 0,2'd3,32'h0,3'b000,0,1,"R3");
    send(0,1,sf(1,1,1,0),2'd2,3'd1,1,3'b111, 0,2'd3,32'h0,3'b000,0,1,"R3");
    // R4 reservation
    send(0,0,sf(1,1,0,0),2'd1,3'd2,1,3'b111, 0,2'd2,32'h0400_0000,3'b000,0,1,"R4");
    send(0,0,sf(1,1,0,0),2'd2,3'd2,1,3'b111, 0,2'd2,32'h0600_0000,3'b000,0,1,"R4");
    // R5 external control, incl. spare class code
    send(0,0,sf(1,0,0,0),2'd1,3'd4,1,3'b111, 0,2'd2,32'h0410_0000,3'b000,0,1,"R5");
    send(0,1,sf(1,0,0,0),2'd2,3'd4,1,3'b111, 0,2'd2,32'h0610_0000,3'b000,0,1,"R5");
    send(0,0,sf(1,0,0,0),2'd2,3'd7,1,3'b111, 0,2'd2,32'h0610_0000,3'b000,0,1,"R5");
    // R6 cache op
    send(0,0,sf(1,0,0,0),2'd2,3'd3,0,3'b000, 1,2'd0,32'h0,3'b000,1,0,"R6");
    send(0,1,sf(1,1,1,0),2'd1,3'd3,0,3'b000, 1,2'd0,32'h0,3'b000,1,0,"R6");
    idle(3);
    // R7 integer, key select
    send(0,0,sf(1,0,1,0),2'd1,3'd0,0,3'b000, 1,2'd0,32'h0,3'b001,1,0,"R7");
    send(0,0,sf(1,0,1,0),2'd2,3'd0,0,3'b000, 0,2'd2,32'h0A00_0000,3'b000,0,1,"R7");
    send(0,1,sf(1,0,1,0),2'd2,3'd0,0,3'b000, 1,2'd0,32'h0,3'b011,1,0,"R7");
    send(0,1,sf(1,1,0,0),2'd2,3'd0,0,3'b000, 0,2'd2,32'h0A00_0000,3'b000,0,1,"R7");
    send(0,0,sf(1,1,0,0),2'd1,3'd0,0,3'b000, 1,2'd0,32'h0,3'b011,1,0,"R7");
    // R8 no-execute
    send(0,0,sf(0,0,0,1),2'd0,3'd0,1,3'b111, 0,2'd1,32'h1000_0000,3'b000,0,0,"R8");
    // R9 miss
    send(0,0,sf(0,0,0,0),2'd0,3'd0,0,3'b111, 0,2'd1,32'h4000_0000,3'b000,0,0,"R9");
    send(0,0,sf(0,0,0,0),2'd1,3'd0,0,3'b111, 0,2'd2,32'h4000_0000,3'b000,0,1,"R9");
    send(0,1,sf(0,0,0,0),2'd2,3'd0,0,3'b111, 0,2'd2,32'h4200_0000,3'b000,0,1,"R9");
    // R10 permissions
    send(0,0,sf(0,0,0,0),2'd0,3'd0,1,3'b011, 0,2'd1,32'h0800_0000,3'b000,0,0,"R10");
    send(0,0,sf(0,0,0,0),2'd1,3'd0,1,3'b110, 0,2'd2,32'h0800_0000,3'b000,0,1,"R10");
    send(0,0,sf(0,0,0,0),2'd2,3'd0,1,3'b101, 0,2'd2,32'h0A00_0000,3'b000,0,1,"R10");
    send(0,0,sf(0,0,0,0),2'd2,3'd0,1,3'b010, 1,2'd0,32'h0,3'b010,0,0,"R10");
    send(0,0,sf(0,0,0,0),2'd3,3'd0,1,3'b001, 1,2'd0,32'h0,3'b001,0,0,"R10");
    send(0,0,sf(0,0,0,0),2'd0,3'd0,1,3'b100, 1,2'd0,32'h0,3'b100,0,0,"R10");
    idle(4);
    check(res_valid == 1'b0 && res_capture == 1'b0, "R11",
          $sformatf("idle got valid=%0d cap=%0d expected 0 0", res_valid, res_capture));
    // R12 precedence
    send(1,0,sf(1,0,0,0),2'd1,3'd1,0,3'b000, 1,2'd0,32'h0,3'b111,1,0,"R12");
    send(0,0,sf(1,1,0,1),2'd1,3'd0,0,3'b000, 1,2'd0,32'h0,3'b011,1,0,"R12");
    send(0,0,sf(0,0,0,1),2'd0,3'd0,0,3'b000, 0,2'd1,32'h1000_0000,3'b000,0,0,"R12");
    send(0,0,sf(0,0,0,1),2'd1,3'd0,1,3'b001, 1,2'd0,32'h0,3'b001,0,0,"R12");
    send(0,0,sf(0,0,0,1),2'd2,3'd0,0,3'b000, 0,2'd2,32'h4200_0000,3'b000,0,1,"R12");
    idle(4);
    check(sb.size() == 0, "R11",
          $sformatf("pending got %0d expected 0", sb.size()));
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule